// File: doc/BRIEF.md
# Bounded Circular Range Counter

This block walks a 16-bit value around a fixed, closed range in steps of fixed size. It reloads the first value of its sequence once the last value has been produced. The first value, the last value, the step size and the direction are elaboration-time parameters. One module therefore serves a rising sequence such as 0, 2, …, 40, a falling one such as 93, 89, …, 5, or a unit-step window high in the 16-bit space.

Inside the block there is a general stepped up/down counter with clear and load, driven by a small controller. The controller asks for a load of the first value in two cases: while the active-low initiate input is held low, and on the edge that follows the last value of the sequence. It asks for a step on every other edge. The inner clear is tied inactive.

The distance between the first and last values must be an exact multiple of the step. This guarantees that the last value is produced exactly.

Top module: `range_cycler`

## Requirements
- R1: While `initN` is 0 at a rising edge of `clk`, `count` takes the value `START_VAL` after that edge.
- R2: For a rising configuration (`COUNT_UP`=1), when `initN` is 1 and `count` is not `END_VAL` at a rising edge, `count` rises by exactly `STEP_VAL` after that edge.
- R3: When `initN` is 1 and `count` equals `END_VAL` at a rising edge, `count` becomes `START_VAL` after that edge instead of stepping.
- R4: For a falling configuration (`COUNT_UP`=0, `START_VAL` above `END_VAL`), when `initN` is 1 and `count` is not `END_VAL` at a rising edge, `count` falls by exactly `STEP_VAL` after that edge.
- R5: After `initN` has been 0 at least once, `count` always lies within the closed range bounded by `START_VAL` and `END_VAL`, and it differs from `START_VAL` by a multiple of `STEP_VAL`.
- R6: Holding `initN` at 0 for several edges keeps `count` at `START_VAL` without stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| initN | input | 1 | Active-low synchronous initiate; loads the first value of the sequence |
| count | output | 16 | Current value of the counter |

## Verification
Every result is due one rising edge after the inputs that cause it. A value of `initN`, or a `count` equal to the last value, present at edge k shows on `count` after edge k. The bench changes `initN` only on falling edges and samples `count` on the following falling edge. Each sample is compared with a model that has advanced by exactly one step for the edge in between. Four instances cover the rising, odd-step, falling and unit-step cases. They share a random initiate pattern mixed with directed holds and complete laps through the wrap point.

// File: rtl/range_cycler_pkg.sv
package range_cycler_pkg;
  // Strobes from controller to datapath
  typedef struct packed {
    logic clearEn;  // force value to zero (highest priority)
    logic loadEn;   // take loadVal
    logic stepUp;   // 1: add step, 0: subtract step
  } ctlStrobes_t;
endpackage

// File: rtl/range_cycler_dp.sv
module range_cycler_dp
  import range_cycler_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  ctlStrobes_t       ctl,
  input  logic [WIDTH-1:0]  loadVal,
  input  logic [STEP_W-1:0] stepAmt,
  output logic [WIDTH-1:0]  value
);
  localparam int PAD_W = WIDTH - STEP_W;

  logic [WIDTH-1:0] stepExt;
  logic [WIDTH-1:0] nextVal;

  assign stepExt = {{PAD_W{1'b0}}, stepAmt};

  always_comb begin
    if (ctl.clearEn)     nextVal = '0;
    else if (ctl.loadEn) nextVal = loadVal;
    else if (ctl.stepUp) nextVal = value + stepExt;
    else                 nextVal = value - stepExt;
  end

  always_ff @(posedge clk) value <= nextVal;

  // R1: a load strobe (without clear) lands loadVal on the next edge
  assert_load_lands_R1: assert property (@(posedge clk)
    disable iff (ctl.clearEn)
    ctl.loadEn |=> value == $past(loadVal));
endmodule

// File: rtl/range_cycler_ctl.sv
module range_cycler_ctl
  import range_cycler_pkg::*;
#(
  parameter int          WIDTH     = 16,
  parameter int unsigned START_VAL = 0,
  parameter int unsigned END_VAL   = 40,
  parameter int unsigned STEP_VAL  = 2,
  parameter bit          COUNT_UP  = 1'b1
) (
  input  logic             clk,
  input  logic             initN,
  input  logic [WIDTH-1:0] value,
  output ctlStrobes_t      ctl
);
  localparam logic [WIDTH-1:0] START_V = WIDTH'(START_VAL);
  localparam logic [WIDTH-1:0] END_V   = WIDTH'(END_VAL);
  localparam logic [WIDTH-1:0] STEP_V  = WIDTH'(STEP_VAL);
  localparam logic [WIDTH-1:0] LO_V    = COUNT_UP ? START_V : END_V;
  localparam logic [WIDTH-1:0] HI_V    = COUNT_UP ? END_V : START_V;

  logic atEnd;
  assign atEnd = (value == END_V);

  always_comb begin
    ctl.clearEn = 1'b0;
    ctl.loadEn  = !initN || atEnd;
    ctl.stepUp  = COUNT_UP;
  end

  // Set once initiate has been seen; used only by the checks below
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!initN) primed <= 1'b1;

  logic [WIDTH-1:0] offset;
  assign offset = COUNT_UP ? (value - START_V) : (START_V - value);

  assert_wrap_to_start_R3: assert property (@(posedge clk)
    disable iff (!initN)
    (primed && atEnd) |=> value == START_V);

  assert_in_range_R5: assert property (@(posedge clk)
    disable iff (!primed || !initN)
    (value >= LO_V) && (value <= HI_V) && ((offset % STEP_V) == '0));

  generate
    if (COUNT_UP) begin : g_up
      assert_step_up_R2: assert property (@(posedge clk)
        disable iff (!initN)
        (primed && !atEnd) |=> value == $past(value) + STEP_V);
    end else begin : g_down
      assert_step_down_R4: assert property (@(posedge clk)
        disable iff (!initN)
        (primed && !atEnd) |=> value == $past(value) - STEP_V);
    end
  endgenerate

  assert_hold_start_R6: assert property (@(posedge clk)
    (!initN && $past(!initN) && primed) |-> value == START_V);
endmodule

// File: rtl/range_cycler.sv
module range_cycler
  import range_cycler_pkg::*;
#(
  parameter int unsigned START_VAL = 0,
  parameter int unsigned END_VAL   = 40,
  parameter int unsigned STEP_VAL  = 2,
  parameter bit          COUNT_UP  = 1'b1,
  parameter int          WIDTH     = 16,
  parameter int          STEP_W    = 3
) (
  input  logic        clk,
  input  logic        initN,
  output logic [15:0] count
);
  localparam logic [WIDTH-1:0]  START_V = WIDTH'(START_VAL);
  localparam logic [STEP_W-1:0] STEP_V  = STEP_W'(STEP_VAL);

  ctlStrobes_t      ctl;
  logic [WIDTH-1:0] value;

  range_cycler_ctl #(
    .WIDTH(WIDTH), .START_VAL(START_VAL), .END_VAL(END_VAL),
    .STEP_VAL(STEP_VAL), .COUNT_UP(COUNT_UP)
  ) u_ctl (
    .clk(clk), .initN(initN), .value(value), .ctl(ctl)
  );

  range_cycler_dp #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .ctl(ctl), .loadVal(START_V), .stepAmt(STEP_V), .value(value)
  );

  assign count = 16'(value);
endmodule

// File: tb/sim_range_cycler.sv
`timescale 1ns/1ps
module sim_range_cycler;
  logic clk = 1'b0;
  logic initN = 1'b0;
  logic [15:0] cnt [4];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  range_cycler u0 (.clk(clk), .initN(initN), .count(cnt[0]));
  range_cycler #(.START_VAL(350),   .END_VAL(371),   .STEP_VAL(3), .COUNT_UP(1'b1))
    u1 (.clk(clk), .initN(initN), .count(cnt[1]));
  range_cycler #(.START_VAL(93),    .END_VAL(5),     .STEP_VAL(4), .COUNT_UP(1'b0))
    u2 (.clk(clk), .initN(initN), .count(cnt[2]));
  range_cycler #(.START_VAL(22525), .END_VAL(22535), .STEP_VAL(1), .COUNT_UP(1'b1))
    u3 (.clk(clk), .initN(initN), .count(cnt[3]));

  int cfgStart [4] = '{0, 350, 93, 22525};
  int cfgEnd   [4] = '{40, 371, 5, 22535};
  int cfgStep  [4] = '{2, 3, 4, 1};
  bit cfgUp    [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
  int model [4];

  function automatic int nextModel(int k, int cur, bit ini);
    if (!ini) return cfgStart[k];
    if (cur == cfgEnd[k]) return cfgStart[k];
    return cfgUp[k] ? cur + cfgStep[k] : cur - cfgStep[k];
  endfunction

  function automatic string reqTag(int k, int cur, bit ini, bit heldBefore);
    if (!ini) return heldBefore ? "R6" : "R1";
    if (cur == cfgEnd[k]) return "R3";
    return cfgUp[k] ? "R2" : "R4";
  endfunction

  function automatic bit inRange(int k, int v);
    int lo = cfgUp[k] ? cfgStart[k] : cfgEnd[k];
    int hi = cfgUp[k] ? cfgEnd[k] : cfgStart[k];
    int off = cfgUp[k] ? v - cfgStart[k] : cfgStart[k] - v;
    return (v >= lo) && (v <= hi) && (off % cfgStep[k] == 0);
  endfunction

  // One edge: drive at negedge, clock, sample at next negedge
  bit prevIni = 1'b1;
  task automatic stepOnce(bit ini);
    string tags [4];
    initN = ini;
    for (int k = 0; k < 4; k++) begin
      tags[k] = reqTag(k, model[k], ini, !prevIni);
      model[k] = nextModel(k, model[k], ini);
    end
    prevIni = ini;
    @(negedge clk);
    cyc++;
    for (int k = 0; k < 4; k++) begin
      total++;
      if (int'(cnt[k]) != model[k]) begin
        bad++;
        $display("FAIL %s inst%0d cyc%0d actual=%0d expected=%0d",
                 tags[k], k, cyc, cnt[k], model[k]);
      end
      total++;
      if (!inRange(k, int'(cnt[k]))) begin  // R5
        bad++;
        $display("FAIL R5 inst%0d cyc%0d actual=%0d expected=in range",
                 k, cyc, cnt[k]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) model[k] = cfgStart[k];
    @(negedge clk);
    // R1 and R6: hold initiate low for several edges
    for (int i = 0; i < 4; i++) stepOnce(1'b0);
    // R2, R3, R4: two complete laps of the longest sequence and beyond
    for (int i = 0; i < 50; i++) stepOnce(1'b1);
    // initiate in the middle of a lap, then a single-edge pulse
    stepOnce(1'b0);
    for (int i = 0; i < 7; i++) stepOnce(1'b1);
    stepOnce(1'b0);
    stepOnce(1'b1);
    // random initiate pattern
    for (int i = 0; i < 800; i++) stepOnce(($urandom % 25) != 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule